// File: doc/BRIEF.md
# Chunk-Gated Transmit Queue Controller

This block sits between a host and a byte serializer in an asynchronous transmitter. The host declares a packet of m+1 bytes and then loads the bytes into a small queue in whole chunks. A chunk is four bytes, or whatever is left of the packet when fewer than four bytes remain. Nothing leaves the queue until a chunk is complete. When a chunk is complete, the clear-to-send line is low and transmission is enabled, the queue hands its bytes to the serializer one at a time through a ready/load handshake.

Once draining has begun it runs to the end of the chunk, even if clear-to-send or the enable is withdrawn. The host may add bytes only while a chunk is being filled. Any other write is dropped and sets a sticky overrun flag.

An empty-queue status drives an interrupt whose polarity is programmable. A packet-complete pulse follows the serializer's report that the final byte has finished. A general-purpose pin can show either a static level or that pulse. A disable input shrinks the chunk to one byte, so each byte goes out as soon as it is written.

Top module: `txq_ctrl`

## Requirements
- R1: After reset, buf_empty is 1, ser_load is 0, overrun is 0 and pkt_done is 0.
- R2: A blk_load pulse with blk_m = m starts a packet of m+1 bytes (m from 0 to 63). It is accepted only while the queue is empty, no chunk is in progress and every byte of the previous packet has been reported by ser_done. Otherwise it is ignored.
- R3: For a packet of 1 to 3 bytes, ser_load stays 0 until the last byte of the packet has been written.
- R4: For a packet of 4 or more bytes, the bytes are taken in chunks of 4, and the final chunk carries the remaining 1 to 3 bytes. Each chunk drains as one run of consecutive loads, and the bytes reach ser_data in write order.
- R5: A completed chunk starts draining only in a cycle where cts_n is 0 and tx_en is 1. Until then it is held.
- R6: Once draining has started, cts_n and tx_en are ignored until the queue is empty.
- R7: A write that arrives while no chunk is being filled, or while the packet has no bytes left to write, is dropped. It sets overrun, which stays 1 until an ovr_clr pulse.
- R8: buf_empty is 1 exactly when the queue holds no byte. irq equals buf_empty when irq_act_hi is 1, and equals its inverse when irq_act_hi is 0.
- R9: pkt_done is a one-cycle pulse. It occurs in the cycle after the ser_done pulse that reports the packet's last byte.
- R10: aux_pin follows pkt_done when aux_sel is 1, and follows aux_level when aux_sel is 0.
- R11: With fifo_off at 1, the chunk size is one byte, so each write drains on its own.
- R12: ser_load is 1 only while draining, with the queue holding a byte and ser_ready at 1. ser_data then carries the oldest byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| blk_load | input | 1 | Start a new packet |
| blk_m | input | 6 | Packet length minus one |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| fifo_off | input | 1 | Use one-byte chunks |
| cts_n | input | 1 | Clear to send, active low |
| tx_en | input | 1 | Transmit enable |
| ser_ready | input | 1 | Serializer can accept a byte |
| ser_done | input | 1 | Serializer finished a byte including its stop bits |
| ser_load | output | 1 | Byte handed to the serializer this cycle |
| ser_data | output | 8 | Byte for the serializer |
| buf_empty | output | 1 | Queue holds no byte |
| irq_act_hi | input | 1 | Interrupt polarity select |
| irq | output | 1 | Empty-queue interrupt |
| overrun | output | 1 | Sticky dropped-write flag |
| ovr_clr | input | 1 | Clear the overrun flag |
| pkt_done | output | 1 | Packet-complete pulse |
| aux_sel | input | 1 | Pin shows pkt_done when 1 |
| aux_level | input | 1 | Static pin level |
| aux_pin | output | 1 | General-purpose output pin |

## Verification
The hardest case to reach from the ports is a chunk that has already entered the draining state when clear-to-send is withdrawn. With a fast serializer, that window lasts only a few cycles. The bench holds ser_ready low while it lowers cts_n, so the chunk enters draining but cannot pop. It then raises cts_n, clears tx_en and releases ser_ready, and checks that all four bytes still go out in order. During the held phase it also makes a stray write and tries a new packet load, and checks that the write is dropped and the load is ignored.

// File: rtl/txq_pkg.sv
// Shared types for the chunk-gated transmit queue.
// Assumes: three control phases are enough to describe the queue.
package txq_pkg;
    typedef enum logic [1:0] {
        TQ_FILL  = 2'd0,  // host may write bytes of the current chunk
        TQ_HOLD  = 2'd1,  // chunk complete, waiting for clear-to-send
        TQ_DRAIN = 2'd2   // handing bytes to the serializer
    } tq_state_e;
endpackage

// File: rtl/txq_fifo.sv
// Byte queue of DEPTH entries with push, pop and an occupancy count.
// Assumes: the controller never pushes when full or pops when empty.
module txq_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [DW-1:0]                din,
    input  logic                         pop,
    output logic [DW-1:0]                dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    // One storage register per entry, written when the write pointer selects it.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[gi] <= '0;
            else if (push && wr_ptr == PW'(gi))
                mem[gi] <= din;
        end
    end

    // Advance the pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= ptr_next(wr_ptr);
            if (pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign dout = mem[rd_ptr];
endmodule

// File: rtl/txq_chunk_ctrl.sv
// Chunk sequencer. It gates host writes into the queue, detects a completed
// chunk, waits for clear-to-send and drains the chunk to the serializer.
// Assumes: count comes from the queue this block controls.
module txq_chunk_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LEN_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic                        blk_load,
    input  logic [LEN_W-1:0]            blk_m,
    input  logic                        pkt_idle,
    input  logic                        fifo_off,
    input  logic                        cts_n,
    input  logic                        tx_en,
    input  logic                        ser_ready,
    input  logic                        ovr_clr,
    input  logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        push,
    output logic                        pop,
    output logic                        load_ok,
    output logic                        overrun,
    output tq_state_e                   st
);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int REM_W = LEN_W + 1;

    logic [REM_W-1:0] rem;       // bytes of the packet not yet written
    logic [CW-1:0]    chunk_sz;  // bytes per chunk in the current mode
    logic             chunk_end; // this push completes the chunk

    // Decide which requests are accepted this cycle.
    always_comb begin
        chunk_sz  = fifo_off ? CW'(1) : CW'(DEPTH);
        load_ok   = blk_load && st == TQ_FILL && count == '0 && pkt_idle;
        push      = wr_en && !blk_load && st == TQ_FILL && rem != '0;
        chunk_end = push && (rem == REM_W'(1) || count + CW'(1) == chunk_sz);
        pop       = st == TQ_DRAIN && count != '0 && ser_ready;
    end

    // Track how many bytes of the packet the host still owes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rem <= '0;
        else if (load_ok)
            rem <= {1'b0, blk_m} + REM_W'(1);
        else if (push)
            rem <= rem - REM_W'(1);
    end

    // Phase sequencing: fill, hold for clear-to-send, drain to empty.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= TQ_FILL;
        end else begin
            case (st)
                TQ_FILL:  if (chunk_end) st <= TQ_HOLD;
                TQ_HOLD:  if (!cts_n && tx_en) st <= TQ_DRAIN;
                TQ_DRAIN: if (pop && count == CW'(1)) st <= TQ_FILL;
                default:  st <= TQ_FILL;
            endcase
        end
    end

    // Sticky record of dropped writes; a new drop wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            overrun <= 1'b0;
        else if (wr_en && !push)
            overrun <= 1'b1;
        else if (ovr_clr)
            overrun <= 1'b0;
    end
endmodule

// File: rtl/txq_pkt_cnt.sv
// Counts the packet's bytes that the serializer has not yet finished, and
// pulses pkt_done when the last one is reported.
// Assumes: ser_done pulses once per byte, after that byte's stop bits.
module txq_pkt_cnt #(
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] blk_m,
    input  logic             ser_done,
    output logic             idle,
    output logic             pkt_done
);
    localparam int LW = LEN_W + 1;

    logic [LW-1:0] left;

    // Load the packet size and count down on each finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left <= '0;
        else if (load)
            left <= {1'b0, blk_m} + LW'(1);
        else if (ser_done && left != '0)
            left <= left - LW'(1);
    end

    // One-cycle pulse after the final byte finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pkt_done <= 1'b0;
        else
            pkt_done <= ser_done && !load && left == LW'(1);
    end

    assign idle = (left == '0);
endmodule

// File: rtl/txq_ctrl.sv
// Top of the chunk-gated transmit queue. It ties the queue, the chunk
// sequencer and the packet counter together, and forms the interrupt and
// the auxiliary pin.
// Assumes: all inputs are synchronous to clk.
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 4,
    parameter int LEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blk_load,
    input  logic [LEN_W-1:0] blk_m,
    input  logic             wr_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             fifo_off,
    input  logic             cts_n,
    input  logic             tx_en,
    input  logic             ser_ready,
    input  logic             ser_done,
    output logic             ser_load,
    output logic [DW-1:0]    ser_data,
    output logic             buf_empty,
    input  logic             irq_act_hi,
    output logic             irq,
    output logic             overrun,
    input  logic             ovr_clr,
    output logic             pkt_done,
    input  logic             aux_sel,
    input  logic             aux_level,
    output logic             aux_pin
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          push, pop, load_ok, pkt_idle;
    logic [CW-1:0] count;
    tq_state_e     st;

    txq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (wr_data),
        .pop   (pop),
        .dout  (ser_data),
        .count (count)
    );

    txq_chunk_ctrl #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .blk_load  (blk_load),
        .blk_m     (blk_m),
        .pkt_idle  (pkt_idle),
        .fifo_off  (fifo_off),
        .cts_n     (cts_n),
        .tx_en     (tx_en),
        .ser_ready (ser_ready),
        .ovr_clr   (ovr_clr),
        .count     (count),
        .push      (push),
        .pop       (pop),
        .load_ok   (load_ok),
        .overrun   (overrun),
        .st        (st)
    );

    txq_pkt_cnt #(.LEN_W(LEN_W)) u_pkt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_ok),
        .blk_m    (blk_m),
        .ser_done (ser_done),
        .idle     (pkt_idle),
        .pkt_done (pkt_done)
    );

    // Status, interrupt polarity and pin routing.
    always_comb begin
        ser_load  = pop;
        buf_empty = (count == '0);
        irq       = irq_act_hi ? buf_empty : !buf_empty;
        aux_pin   = aux_sel ? pkt_done : aux_level;
    end
endmodule

// File: rtl/txq_chk.sv
// Property checker for txq_ctrl, attached by bind.
// Assumes: st and count are the top's internal sequencer state and occupancy.
module txq_chk
    import txq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        cts_n,
    input logic                        tx_en,
    input logic                        ser_ready,
    input logic                        ser_load,
    input logic                        ser_done,
    input logic                        buf_empty,
    input logic                        irq_act_hi,
    input logic                        irq,
    input logic                        overrun,
    input logic                        ovr_clr,
    input logic                        pkt_done,
    input logic [$clog2(DEPTH+1)-1:0]  count,
    input tq_state_e                   st
);
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= ($clog2(DEPTH+1))'(DEPTH));

    // R12
    load_has_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_load |-> (!buf_empty && ser_ready && st == TQ_DRAIN));

    // R5
    drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TQ_DRAIN && $past(st == TQ_HOLD)) |-> $past(!cts_n && tx_en));

    // R6
    drain_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == TQ_DRAIN && count > 1) |=> st == TQ_DRAIN);

    // R7
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !ovr_clr) |=> overrun);

    // R9
    pkt_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> ($past(ser_done) && !$past(pkt_done)));

    // R8
    irq_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_act_hi && $fell(buf_empty)) |-> !irq);
endmodule

bind txq_ctrl txq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cts_n      (cts_n),
    .tx_en      (tx_en),
    .ser_ready  (ser_ready),
    .ser_load   (ser_load),
    .ser_done   (ser_done),
    .buf_empty  (buf_empty),
    .irq_act_hi (irq_act_hi),
    .irq        (irq),
    .overrun    (overrun),
    .ovr_clr    (ovr_clr),
    .pkt_done   (pkt_done),
    .count      (count),
    .st         (st)
);

// File: tb/tb_txq_ctrl.sv
module tb_txq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       blk_load = 1'b0;
    logic [5:0] blk_m = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_off = 1'b0;
    logic       cts_n = 1'b1;
    logic       tx_en = 1'b0;
    logic       ser_ready = 1'b1;
    logic       ser_done;
    logic       ser_load;
    logic [7:0] ser_data;
    logic       buf_empty;
    logic       irq_act_hi = 1'b1;
    logic       irq;
    logic       overrun;
    logic       ovr_clr = 1'b0;
    logic       pkt_done;
    logic       aux_sel = 1'b0;
    logic       aux_level = 1'b0;
    logic       aux_pin;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    txq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .blk_load(blk_load), .blk_m(blk_m),
        .wr_en(wr_en), .wr_data(wr_data), .fifo_off(fifo_off),
        .cts_n(cts_n), .tx_en(tx_en), .ser_ready(ser_ready),
        .ser_done(ser_done), .ser_load(ser_load), .ser_data(ser_data),
        .buf_empty(buf_empty), .irq_act_hi(irq_act_hi), .irq(irq),
        .overrun(overrun), .ovr_clr(ovr_clr), .pkt_done(pkt_done),
        .aux_sel(aux_sel), .aux_level(aux_level), .aux_pin(aux_pin)
    );

    // Serializer model and recorder: finishes each loaded byte one cycle later.
    logic [7:0] got [256];
    int  got_n, bursts, pd_n, aux_n;
    logic prev_load;
    always @(posedge clk) begin
        if (!rst_n) begin
            got_n <= 0; bursts <= 0; pd_n <= 0; aux_n <= 0;
            prev_load <= 1'b0; ser_done <= 1'b0;
        end else begin
            if (ser_load) begin
                got[got_n[7:0]] <= ser_data;
                got_n <= got_n + 1;
            end
            if (ser_load && !prev_load) bursts <= bursts + 1;
            prev_load <= ser_load;
            ser_done  <= ser_load;
            if (pkt_done) pd_n <= pd_n + 1;
            if (aux_pin && aux_sel) aux_n <= aux_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_pkt(input logic [5:0] m);
        blk_load = 1'b1; blk_m = m;
        @(negedge clk);
        blk_load = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int v, input int i);
        return 8'((v * 37 + i * 5 + 1) & 255);
    endfunction

    // Vector table: {packet m, expected number of drain runs}
    localparam int NV = 5;
    localparam logic [9:0] VEC [NV] = '{
        {6'd0, 4'd1}, {6'd2, 4'd1}, {6'd3, 4'd1}, {6'd4, 4'd2}, {6'd9, 4'd3}
    };

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(buf_empty == 1'b1, "R1 buf_empty", int'(buf_empty), 1);
        chk(ser_load == 1'b0, "R1 ser_load", int'(ser_load), 0);
        chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);
        chk(pkt_done == 1'b0, "R1 pkt_done", int'(pkt_done), 0);
        // R8 polarity while empty
        chk(irq == 1'b1, "R8 irq high-active empty", int'(irq), 1);
        irq_act_hi = 1'b0; #1;
        chk(irq == 1'b0, "R8 irq low-active empty", int'(irq), 0);
        irq_act_hi = 1'b1;

        // Table walk: R2 R3 R4 R5 R9 R12
        cts_n = 1'b0; tx_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            int m, n, base, b0, p0, wrote;
            m = int'(VEC[v][9:4]); n = m + 1;
            base = got_n; b0 = bursts; p0 = pd_n; wrote = 0;
            load_pkt(VEC[v][9:4]);
            while (wrote < n) begin
                int k;
                k = (n - wrote > 4) ? 4 : n - wrote;
                for (int j = 0; j < k; j++) begin
                    wr(pat(v, wrote + j));
                    if (j < k - 1) begin
                        chk(ser_load == 1'b0, "R3 no load before chunk end", int'(ser_load), 0);
                        chk(irq == 1'b0, "R8 irq while filling", int'(irq), 0);
                    end
                end
                repeat (10) @(negedge clk);
                chk(buf_empty == 1'b1, "R4 chunk drained", int'(buf_empty), 1);
                wrote += k;
            end
            repeat (4) @(negedge clk);
            chk(got_n - base == n, "R4 byte count", got_n - base, n);
            for (int i = 0; i < n; i++)
                chk(got[(base + i) & 255] == pat(v, i), "R12 byte order",
                    int'(got[(base + i) & 255]), int'(pat(v, i)));
            chk(bursts - b0 == int'(VEC[v][3:0]), "R4 drain runs",
                bursts - b0, int'(VEC[v][3:0]));
            chk(pd_n - p0 == 1, "R9 one packet pulse", pd_n - p0, 1);
        end

        // R5 hold, R7 overrun, R2 ignored load, R6 drain ignores CTS
        begin
            int base, p0;
            base = got_n; p0 = pd_n;
            cts_n = 1'b1;
            load_pkt(6'd3);
            for (int i = 0; i < 4; i++) wr(8'hA0 + 8'(i));
            repeat (6) @(negedge clk);
            chk(got_n == base, "R5 held without CTS", got_n - base, 0);
            wr(8'hEE);
            chk(overrun == 1'b1, "R7 overrun on held write", int'(overrun), 1);
            load_pkt(6'd0);
            ser_ready = 1'b0; cts_n = 1'b0;
            repeat (3) @(negedge clk);
            chk(got_n == base, "R12 no load without ready", got_n - base, 0);
            cts_n = 1'b1; tx_en = 1'b0; ser_ready = 1'b1;
            repeat (8) @(negedge clk);
            chk(got_n - base == 4, "R6 chunk finishes after CTS drop", got_n - base, 4);
            for (int i = 0; i < 4; i++)
                chk(got[(base + i) & 255] == 8'hA0 + 8'(i), "R6 byte order",
                    int'(got[(base + i) & 255]), 160 + i);
            chk(pd_n - p0 == 1, "R2 load ignored while busy", pd_n - p0, 1);
            chk(overrun == 1'b1, "R7 overrun sticky", int'(overrun), 1);
            ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
            chk(overrun == 1'b0, "R7 overrun cleared", int'(overrun), 0);
            // R7 write with no packet open
            wr(8'h55);
            repeat (3) @(negedge clk);
            chk(overrun == 1'b1, "R7 write with no packet", int'(overrun), 1);
            chk(buf_empty == 1'b1, "R7 dropped byte not queued", int'(buf_empty), 1);
            ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
        end

        // R11 one-byte chunks, R10 pin routing
        begin
            int base, b0, a0;
            base = got_n; b0 = bursts; a0 = aux_n;
            fifo_off = 1'b1; cts_n = 1'b0; tx_en = 1'b1; aux_sel = 1'b1;
            load_pkt(6'd2);
            wr(8'h31);
            repeat (6) @(negedge clk);
            chk(got_n - base == 1, "R11 single byte drains", got_n - base, 1);
            wr(8'h32); repeat (6) @(negedge clk);
            wr(8'h33); repeat (8) @(negedge clk);
            chk(bursts - b0 == 3, "R11 one run per byte", bursts - b0, 3);
            chk(aux_n - a0 == 1, "R10 pin shows packet pulse", aux_n - a0, 1);
            aux_sel = 1'b0; aux_level = 1'b1; #1;
            chk(aux_pin == 1'b1, "R10 pin static high", int'(aux_pin), 1);
            aux_level = 1'b0; #1;
            chk(aux_pin == 1'b0, "R10 pin static low", int'(aux_pin), 0);
            fifo_off = 1'b0;
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule